// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block produces all refresh traffic for an EDO DRAM array that uses the devices' internal row counters. Column strobes are taken low before row strobes, so the address and data buses are don't-care during refresh and stay with the access controller. After reset it waits out the power-up pause. It then runs a fixed number of dummy refresh cycles and raises `ready` to tell the host that normal accesses may begin.

After initialization, a free-running interval timer adds one refresh to a saturating pending count each period. While any refresh is pending, the block raises `refReq` toward the access controller. Once `refGrant` is seen, it takes over the strobes and serves every pending refresh back to back. Each refresh is framed by a row precharge. `refReq` drops when the last precharge completes, and the controller then takes the pins back. All row strobes and all column strobes switch together, and write enable is never driven low. Each pin is driven from a register, so the pins lag the internal sequence by one clock.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held, and in the first clock after it is released, every row strobe, column strobe and write enable is high, and `ready` and `refReq` are 0.
- R2: After reset is released, `refReq` stays 0 and the strobes stay high for at least PAUSE_CYC clocks.
- R3: Once the pause ends, `refReq` rises. When granted, exactly INIT_CYCLES refresh cycles run back to back. `ready` rises after that burst and never falls again.
- R4: In every refresh cycle the column strobes fall exactly T_CSR clocks before the row strobes fall. They stay low for exactly T_CHR clocks after the row strobes fall, then rise while the row strobes are still low.
- R5: The row strobes stay low for exactly T_RAS clocks per refresh. They are high for at least T_RP clocks before each fall, and for at least T_RP clocks before `refReq` drops at the end of a burst.
- R6: All NUM_RAS row strobes carry the same level at all times, and so do all NUM_CAS column strobes. Write enable is high at all times.
- R7: After `ready` rises, consecutive rises of `refReq` are exactly INTERVAL_CYC clocks apart, provided each burst is served within the interval.
- R8: Refreshes that come due while the grant is withheld accumulate. The next grant serves all of them in one burst before `refReq` drops.
- R9: The pending count saturates at MAX_PEND. A grant that arrives after more periods than that have elapsed serves exactly MAX_PEND refreshes.
- R10: Whenever `refReq` is 0, or while a request waits for the grant, every strobe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refGrant | input | 1 | Access controller hands the strobes to this block; held until `refReq` drops |
| refReq | output | 1 | Refresh work pending or in progress |
| ready | output | 1 | Initialization finished; normal accesses allowed |
| rasN | output | NUM_RAS | Row strobes, active low |
| casN | output | NUM_CAS | Column strobes, active low |
| weN | output | 1 | Write enable, active low, held high |

## Verification
The sequencer is first exercised through the initialization burst, which checks the pause length and the dummy-cycle count. Next comes a run of promptly granted single refreshes, which isolates the timer period from any queuing. A grant held back for a little over three periods must produce a burst of four, showing that requests accumulate. A grant held back for over ten periods must produce a burst of exactly MAX_PEND, which separates saturation from both dropping and wrapping. A monitor measures every strobe edge in all of these patterns, so cycle shape and precharge spacing are checked under single and burst operation alike.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

  // Strobe command from the sequencer to the pin stage.
  typedef struct packed {
    logic casLow;
    logic rasLow;
  } strobeCmd_t;

  typedef enum logic [2:0] {
    S_PAUSE,
    S_IDLE,
    S_PRE,
    S_CSR,
    S_CHR,
    S_RSH
  } seqState_t;

endpackage

// File: rtl/dram_refresh_ctl.sv
module dram_refresh_ctl
  import dram_refresh_pkg::*;
#(
  parameter int PAUSE_CYC    = 40000,
  parameter int INTERVAL_CYC = 3120,
  parameter int INIT_CYCLES  = 8,
  parameter int MAX_PEND     = 8,
  parameter int T_RP         = 8,
  parameter int T_CSR        = 2,
  parameter int T_CHR        = 2,
  parameter int T_RAS        = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refGrant,
  output logic       refReq,
  output logic       ready,
  output strobeCmd_t cmd
);

  localparam int PEND_TOP = (MAX_PEND > INIT_CYCLES) ? MAX_PEND : INIT_CYCLES;
  localparam int PEND_W   = $clog2(PEND_TOP + 1);
  localparam int PAUSE_W  = $clog2(PAUSE_CYC + 1);
  localparam int TICK_W   = $clog2(INTERVAL_CYC + 1);
  localparam int PH_W     = $clog2(T_RP + T_CSR + T_RAS + 1);

  localparam logic [PEND_W-1:0]  PEND_CAP  = PEND_W'(MAX_PEND);
  localparam logic [PEND_W-1:0]  PEND_INIT = PEND_W'(INIT_CYCLES);
  localparam logic [TICK_W-1:0]  TICK_LAST = TICK_W'(INTERVAL_CYC - 1);
  localparam logic [PAUSE_W-1:0] PAUSE_LD  = PAUSE_W'(PAUSE_CYC - 1);
  localparam logic [PH_W-1:0]    LD_RP     = PH_W'(T_RP - 1);
  localparam logic [PH_W-1:0]    LD_CSR    = PH_W'(T_CSR - 1);
  localparam logic [PH_W-1:0]    LD_CHR    = PH_W'(T_CHR - 1);
  localparam logic [PH_W-1:0]    LD_RSH    = PH_W'(T_RAS - T_CHR - 1);

  seqState_t           state;
  logic [PAUSE_W-1:0]  pauseCnt;
  logic [PH_W-1:0]     phCnt;
  logic [TICK_W-1:0]   tickCnt;
  logic [PEND_W-1:0]   pending, pendNext;
  logic                tickHit, phDone, rowDone, pauseDone, addOk;

  assign tickHit   = ready && (tickCnt == TICK_LAST);
  assign phDone    = (phCnt == '0);
  assign rowDone   = (state == S_RSH) && phDone;
  assign pauseDone = (state == S_PAUSE) && (pauseCnt == '0);
  assign addOk     = tickHit && (pending != PEND_CAP);

  always_comb begin
    pendNext = pending;
    if (pauseDone)              pendNext = PEND_INIT;
    else if (addOk && !rowDone) pendNext = pending + 1'b1;
    else if (!addOk && rowDone) pendNext = pending - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_PAUSE;
      pauseCnt <= PAUSE_LD;
      phCnt    <= '0;
      tickCnt  <= '0;
      pending  <= '0;
      ready    <= 1'b0;
    end else begin
      pending <= pendNext;
      if (ready) tickCnt <= tickHit ? '0 : tickCnt + 1'b1;
      if (!ready && state == S_IDLE && pending == '0) ready <= 1'b1;
      unique case (state)
        S_PAUSE: if (pauseDone) state <= S_IDLE;
                 else pauseCnt <= pauseCnt - 1'b1;
        S_IDLE:  if (pending != '0 && refGrant) begin
                   state <= S_PRE;
                   phCnt <= LD_RP;
                 end
        S_PRE:   if (!phDone) phCnt <= phCnt - 1'b1;
                 else if (pending != '0) begin
                   state <= S_CSR;
                   phCnt <= LD_CSR;
                 end else state <= S_IDLE;
        S_CSR:   if (!phDone) phCnt <= phCnt - 1'b1;
                 else begin
                   state <= S_CHR;
                   phCnt <= LD_CHR;
                 end
        S_CHR:   if (!phDone) phCnt <= phCnt - 1'b1;
                 else begin
                   state <= S_RSH;
                   phCnt <= LD_RSH;
                 end
        S_RSH:   if (!phDone) phCnt <= phCnt - 1'b1;
                 else begin
                   state <= S_PRE;
                   phCnt <= LD_RP;
                 end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign refReq     = (state != S_PAUSE) && ((pending != '0) || (state != S_IDLE));
  assign cmd.casLow = (state == S_CSR) || (state == S_CHR);
  assign cmd.rasLow = (state == S_CHR) || (state == S_RSH);

endmodule

// File: rtl/dram_refresh_pins.sv
module dram_refresh_pins
  import dram_refresh_pkg::*;
#(
  parameter int NUM_RAS = 4,
  parameter int NUM_CAS = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeCmd_t         cmd,
  output logic [NUM_RAS-1:0] rasN,
  output logic [NUM_CAS-1:0] casN,
  output logic               weN
);

  // One flop per pin so each strobe has its own driver.
  for (genvar i = 0; i < NUM_RAS; i++) begin : g_ras
    always_ff @(posedge clk) begin
      if (!rstN) rasN[i] <= 1'b1;
      else       rasN[i] <= ~cmd.rasLow;
    end
  end

  for (genvar j = 0; j < NUM_CAS; j++) begin : g_cas
    always_ff @(posedge clk) begin
      if (!rstN) casN[j] <= 1'b1;
      else       casN[j] <= ~cmd.casLow;
    end
  end

  assign weN = 1'b1;

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_refresh_pkg::*;
#(
  parameter int PAUSE_CYC    = 40000,
  parameter int INTERVAL_CYC = 3120,
  parameter int INIT_CYCLES  = 8,
  parameter int MAX_PEND     = 8,
  parameter int T_RP         = 8,
  parameter int T_CSR        = 2,
  parameter int T_CHR        = 2,
  parameter int T_RAS        = 12,
  parameter int NUM_RAS      = 4,
  parameter int NUM_CAS      = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refGrant,
  output logic               refReq,
  output logic               ready,
  output logic [NUM_RAS-1:0] rasN,
  output logic [NUM_CAS-1:0] casN,
  output logic               weN
);

  strobeCmd_t cmd;

  dram_refresh_ctl #(
    .PAUSE_CYC(PAUSE_CYC), .INTERVAL_CYC(INTERVAL_CYC), .INIT_CYCLES(INIT_CYCLES),
    .MAX_PEND(MAX_PEND), .T_RP(T_RP), .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .refGrant(refGrant),
    .refReq(refReq), .ready(ready), .cmd(cmd)
  );

  dram_refresh_pins #(.NUM_RAS(NUM_RAS), .NUM_CAS(NUM_CAS)) u_pins (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .rasN(rasN), .casN(casN), .weN(weN)
  );

endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int NUM_RAS = 4,
  parameter int NUM_CAS = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               refGrant,
  input logic               refReq,
  input logic               ready,
  input logic [NUM_RAS-1:0] rasN,
  input logic [NUM_CAS-1:0] casN,
  input logic               weN
);

  // R3
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);

  // R4
  cas_before_ras_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN[0]) |-> (casN[0] == 1'b0) && $past(casN[0] == 1'b0));

  // R4
  cas_up_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN[0]) |-> casN[0]);

  // R10
  idle_pins_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !refReq |-> (&rasN) && (&casN));

  // R10
  strobes_need_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rasN[0] || !casN[0]) |-> refGrant);

  // R6
  we_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN[0]) |-> weN);

endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(.NUM_RAS(NUM_RAS), .NUM_CAS(NUM_CAS)) u_chk (
  .clk(clk), .rstN(rstN), .refGrant(refGrant), .refReq(refReq), .ready(ready),
  .rasN(rasN), .casN(casN), .weN(weN)
);

// File: tb/dram_refresh_seq_bench.sv
module dram_refresh_seq_bench;

  localparam int PAUSE    = 60;
  localparam int INTERVAL = 300;
  localparam int INITN    = 8;
  localparam int MAXP     = 8;
  localparam int TRP      = 8;
  localparam int TCSR     = 2;
  localparam int TCHR     = 2;
  localparam int TRAS     = 12;
  localparam int NR       = 4;
  localparam int NC       = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refGrant = 1'b0;
  logic refReq, ready, weN;
  logic [NR-1:0] rasN;
  logic [NC-1:0] casN;

  int nChk = 0;
  int nFail = 0;
  int expQ[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CYC(PAUSE), .INTERVAL_CYC(INTERVAL), .INIT_CYCLES(INITN), .MAX_PEND(MAXP),
    .T_RP(TRP), .T_CSR(TCSR), .T_CHR(TCHR), .T_RAS(TRAS), .NUM_RAS(NR), .NUM_CAS(NC)
  ) u_dram_refresh_seq (
    .clk(clk), .rstN(rstN), .refGrant(refGrant), .refReq(refReq), .ready(ready),
    .rasN(rasN), .casN(casN), .weN(weN)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  // Monitor: measures every strobe edge and pops burst sizes at refReq fall.
  logic prevR = 1'b1, prevC = 1'b1, prevQ = 1'b0;
  int casLowRun = 0, rasHighRun = 0, rasLowRun = 0, casHoldRun = 0, burstCnt = 0;

  always @(negedge clk) begin
    if (rstN) begin
      logic r, c;
      r = rasN[0];
      c = casN[0];
      // R6
      if (rasN != {NR{r}} || casN != {NC{c}} || weN !== 1'b1)
        chk(1'b0, "R6", "strobes split or write enable low", int'(rasN), int'({NR{r}}));
      if (prevR && !r) begin
        // R4
        chk(!c && casLowRun == TCSR, "R4", "column lead before row fall", casLowRun, TCSR);
        // R5
        chk(rasHighRun >= TRP, "R5", "row precharge before fall", rasHighRun, TRP);
      end
      if (!prevC && c && !r)
        chk(casHoldRun == TCHR, "R4", "column hold after row fall", casHoldRun, TCHR);
      if (!prevR && r) begin
        chk(rasLowRun == TRAS, "R5", "row low width", rasLowRun, TRAS);
        chk(c == 1'b1, "R4", "column high at row rise", int'(c), 1);
        burstCnt++;
      end
      casLowRun  = c ? 0 : casLowRun + 1;
      rasHighRun = r ? rasHighRun + 1 : 0;
      rasLowRun  = r ? 0 : rasLowRun + 1;
      casHoldRun = (!r && !c) ? casHoldRun + 1 : 0;
      if (prevQ && !refReq) begin
        chk(rasHighRun >= TRP, "R5", "trailing precharge", rasHighRun, TRP);
        if (expQ.size() == 0) chk(1'b0, "R8", "unexpected burst end", burstCnt, 0);
        else begin
          int e;
          e = expQ.pop_front();
          chk(burstCnt == e, "R8", "refreshes in burst", burstCnt, e);
        end
        burstCnt = 0;
      end
      prevR = r;
      prevC = c;
      prevQ = refReq;
    end
  end

  // Driver: grant one burst and queue its expected size.
  task automatic serve(input int n);
    expQ.push_back(n);
    refGrant = 1'b1;
    do @(negedge clk); while (refReq);
    refGrant = 1'b0;
  endtask

  task automatic waitRise(output int t);
    t = 0;
    do begin @(negedge clk); t++; end while (!refReq);
  endtask

  task automatic holdOff(input int cyc);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (i % 50 == 25)
        // R10
        chk(refReq && (&rasN) && (&casN), "R10", "strobes high while grant withheld",
            int'({refReq, rasN[0], casN[0]}), 7);
    end
  endtask

  initial begin
    int t, tPrev;
    // R1
    repeat (4) @(negedge clk);
    chk((&rasN) && (&casN) && weN && !ready && !refReq, "R1", "state in reset",
        int'({rasN[0], casN[0], weN, ready, refReq}), 28);
    rstN = 1'b1;
    @(negedge clk);
    chk((&rasN) && (&casN) && !ready && !refReq, "R1", "state after release",
        int'({rasN[0], casN[0], ready, refReq}), 12);
    // R2
    t = 1;
    while (!refReq) begin
      if (!((&rasN) && (&casN) && !ready)) chk(1'b0, "R2", "pins during pause", t, 0);
      @(negedge clk);
      t++;
    end
    chk(t >= PAUSE && t <= PAUSE + 1, "R2", "pause length", t, PAUSE);
    // R10
    holdOff(60);
    // R3
    chk(ready == 1'b0, "R3", "ready before init burst", int'(ready), 0);
    serve(INITN);
    repeat (2) @(negedge clk);
    chk(ready == 1'b1, "R3", "ready after init burst", int'(ready), 1);
    // R7
    tPrev = 0;
    for (int k = 0; k < 4; k++) begin
      waitRise(t);
      if (k > 0) chk(t + tPrev == INTERVAL, "R7", "request period", t + tPrev, INTERVAL);
      tPrev = 0;
      expQ.push_back(1);
      refGrant = 1'b1;
      do begin @(negedge clk); tPrev++; end while (refReq);
      refGrant = 1'b0;
    end
    // R8
    waitRise(t);
    holdOff(INTERVAL * 3 + INTERVAL / 4);
    serve(4);
    // R9
    waitRise(t);
    holdOff(INTERVAL * 10 + INTERVAL / 4);
    serve(MAXP);
    repeat (4) @(negedge clk);
    chk(ready == 1'b1, "R3", "ready stays high", int'(ready), 1);
    chk(expQ.size() == 0, "R8", "all bursts seen", expQ.size(), 0);
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
      summary();
    end
  end

endmodule